// File: doc/BRIEF.md
# Receive Flow-Character and Special-Character Filter

This block sits between a serial receiver and its receive FIFO. Each time the receiver finishes a character, the block decides three things. It decides whether the character goes into the FIFO. It decides whether the character is a software flow-control command that should stop or restart the local transmitter. It decides whether the character matches the programmed special character, in which case it raises a sticky status bit.

Two pairs of flow characters are programmed as inputs, each pair being an Xon and an Xoff. A two-bit compare mode selects which pairs are live. The special-character comparison always uses the Xoff of the second pair. The same comparator therefore serves both features. When the second pair is live, that character is swallowed as a flow command and is still reported as special. When only the first pair is live, the special character is stored and flagged like any ordinary data.

All decisions are registered on the clock edge that samples the character strobe.

Top module: `rx_flowchar_detect`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `fifo_wr`, `spec_stat`, `xoff_irq`, `tx_halt` and `tx_resume` are all low.
- R2: Every output reacts one clock edge after `chr_valid` is sampled. When `chr_valid` is low, that edge produces no `fifo_wr`, `xoff_irq` or `tx_resume`. Whenever `fifo_wr` is high, `fifo_wdata` equals the character that was sampled.
- R3: With `flow_mode` = 00, every valid character is written to the FIFO. No halt, resume or Xoff interrupt is produced.
- R4: When `spec_en` is high and a valid character equals `xoff_chars[15:8]` bit for bit (bit 0 against the character LSB), `spec_stat` goes high. When `spec_en` is low, `spec_stat` is never set.
- R5: `spec_stat` stays high until a cycle with `stat_rd` high clears it. A new match in the same cycle as `stat_rd` keeps it set.
- R6: `flow_mode` bit 1 makes pair 1 live (`xon_chars[7:0]`, `xoff_chars[7:0]`). A live Xoff sets `tx_halt` and pulses `xoff_irq`. A live Xon clears `tx_halt` and pulses `tx_resume`. Neither character is stored.
- R7: With `flow_mode` = 10, a character equal to `xoff_chars[15:8]` is stored and flagged as special, with no flow effect.
- R8: `flow_mode` bit 0 makes pair 2 live. With `flow_mode` = 01, a received `xoff_chars[15:8]` is not stored. It pulses `xoff_irq`, sets `tx_halt`, and sets `spec_stat` when `spec_en` is high. `xon_chars[15:8]` resumes the transmitter and is not stored. Pair 1 characters are stored as data.
- R9: With `flow_mode` = 11, the flow characters of both pairs are live.
- R10: A character that matches both a live Xon and a live Xoff acts as an Xoff.
- R11: `tx_halt` holds its value across non-flow characters and idle cycles. Every live Xon pulses `tx_resume`, including when the transmitter is not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_valid | input | 1 | One-cycle strobe: a received character is complete |
| chr_data | input | 8 | Received character |
| spec_en | input | 1 | Special-character detection enable |
| flow_mode | input | 2 | Live pairs: bit 1 = pair 1, bit 0 = pair 2 |
| xon_chars | input | 16 | Xon characters: [7:0] pair 1, [15:8] pair 2 |
| xoff_chars | input | 16 | Xoff characters: [7:0] pair 1, [15:8] pair 2 (also the special character) |
| stat_rd | input | 1 | Status read strobe; clears `spec_stat` |
| fifo_wr | output | 1 | Write-enable to the receive FIFO |
| fifo_wdata | output | 8 | Character to write |
| spec_stat | output | 1 | Sticky special-character status bit |
| xoff_irq | output | 1 | One-cycle pulse: live Xoff received |
| tx_halt | output | 1 | Transmitter halt level |
| tx_resume | output | 1 | One-cycle pulse: live Xon received |

## Verification
Every result is due exactly one rising edge after the strobe that causes it. This covers the FIFO write, the Xoff and resume pulses, the halt level and the status bit. The bench drives inputs on the falling edge and compares all outputs on the next falling edge against a model stepped once per cycle. Each comparison therefore falls half a period after the edge that should have produced the result, and before the next edge could change it. Idle and cleared-status cycles are checked the same way, so a stray pulse or a late clear shows up in the cycle it occurs.

// File: rtl/rxfd_pkg.sv
package rxfd_pkg;
    localparam int CHAR_W = 8;

    typedef logic [CHAR_W-1:0] char_t;

    typedef struct packed {
        logic xon;
        logic xoff;
        logic spec;
    } hit_t;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_HALT   = 2'd1,
        EV_RESUME = 2'd2
    } flow_ev_e;

    typedef struct packed {
        logic     store;
        flow_ev_e ev;
        logic     spec;
        char_t    data;
    } verdict_t;

    function automatic flow_ev_e pick_event(input logic valid, input hit_t h);
        if (!valid)
            return EV_NONE;
        else if (h.xoff)
            return EV_HALT;
        else if (h.xon)
            return EV_RESUME;
        return EV_NONE;
    endfunction
endpackage

// File: rtl/rxfd_match.sv
module rxfd_match
    import rxfd_pkg::*;
#(
    parameter int NUM_PAIRS = 2,
    parameter int SPEC_PAIR = 1
) (
    input  char_t                         rx_char,
    input  logic [NUM_PAIRS*CHAR_W-1:0]   xon_tbl,
    input  logic [NUM_PAIRS*CHAR_W-1:0]   xoff_tbl,
    input  logic [NUM_PAIRS-1:0]          mode,
    input  logic                          spec_en,
    output hit_t                          hit
);
    logic [NUM_PAIRS-1:0] on_hit;
    logic [NUM_PAIRS-1:0] off_hit;

    // Pair k is live when mode bit (NUM_PAIRS-1-k) is set.
    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        logic live;
        assign live       = mode[NUM_PAIRS-1-k];
        assign on_hit[k]  = live && (rx_char == xon_tbl[k*CHAR_W +: CHAR_W]);
        assign off_hit[k] = live && (rx_char == xoff_tbl[k*CHAR_W +: CHAR_W]);
    end

    always_comb begin
        hit.xon  = |on_hit;
        hit.xoff = |off_hit;
        hit.spec = spec_en && (rx_char == xoff_tbl[SPEC_PAIR*CHAR_W +: CHAR_W]);
    end
endmodule

// File: rtl/rxfd_decide.sv
module rxfd_decide
    import rxfd_pkg::*;
(
    input  logic     valid,
    input  char_t    rx_char,
    input  hit_t     hit,
    output verdict_t verdict
);
    always_comb begin
        verdict.data  = rx_char;
        verdict.ev    = pick_event(valid, hit);
        verdict.store = valid && !hit.xon && !hit.xoff;
        verdict.spec  = valid && hit.spec;
    end
endmodule

// File: rtl/rxfd_flowreg.sv
module rxfd_flowreg
    import rxfd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t verdict,
    input  logic     stat_rd,
    output logic     fifo_wr,
    output char_t    fifo_wdata,
    output logic     spec_stat,
    output logic     xoff_irq,
    output logic     tx_halt,
    output logic     tx_resume
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
            spec_stat  <= 1'b0;
            xoff_irq   <= 1'b0;
            tx_halt    <= 1'b0;
            tx_resume  <= 1'b0;
        end else begin
            fifo_wr    <= verdict.store;
            fifo_wdata <= verdict.data;
            spec_stat  <= verdict.spec || (spec_stat && !stat_rd);
            xoff_irq   <= (verdict.ev == EV_HALT);
            tx_resume  <= (verdict.ev == EV_RESUME);
            case (verdict.ev)
                EV_HALT:   tx_halt <= 1'b1;
                EV_RESUME: tx_halt <= 1'b0;
                default:   tx_halt <= tx_halt;
            endcase
        end
    end
endmodule

// File: rtl/rx_flowchar_detect.sv
module rx_flowchar_detect #(
    parameter int NUM_PAIRS = 2,
    parameter int SPEC_PAIR = 1,
    localparam int TBL_W    = NUM_PAIRS * rxfd_pkg::CHAR_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        chr_valid,
    input  logic [rxfd_pkg::CHAR_W-1:0] chr_data,
    input  logic                        spec_en,
    input  logic [NUM_PAIRS-1:0]        flow_mode,
    input  logic [TBL_W-1:0]            xon_chars,
    input  logic [TBL_W-1:0]            xoff_chars,
    input  logic                        stat_rd,
    output logic                        fifo_wr,
    output logic [rxfd_pkg::CHAR_W-1:0] fifo_wdata,
    output logic                        spec_stat,
    output logic                        xoff_irq,
    output logic                        tx_halt,
    output logic                        tx_resume
);
    rxfd_pkg::hit_t     hit;
    rxfd_pkg::verdict_t verdict;

    rxfd_match #(.NUM_PAIRS(NUM_PAIRS), .SPEC_PAIR(SPEC_PAIR)) u_match (
        .rx_char  (chr_data),
        .xon_tbl  (xon_chars),
        .xoff_tbl (xoff_chars),
        .mode     (flow_mode),
        .spec_en  (spec_en),
        .hit      (hit)
    );

    rxfd_decide u_decide (
        .valid   (chr_valid),
        .rx_char (chr_data),
        .hit     (hit),
        .verdict (verdict)
    );

    rxfd_flowreg u_regs (
        .clk        (clk),
        .rst        (rst),
        .verdict    (verdict),
        .stat_rd    (stat_rd),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .spec_stat  (spec_stat),
        .xoff_irq   (xoff_irq),
        .tx_halt    (tx_halt),
        .tx_resume  (tx_resume)
    );
endmodule

// File: rtl/rx_flowchar_detect_chk.sv
module rx_flowchar_detect_chk #(
    parameter int NUM_PAIRS = 2,
    parameter int SPEC_PAIR = 1
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           chr_valid,
    input logic [7:0]                     chr_data,
    input logic                           spec_en,
    input logic [NUM_PAIRS-1:0]           flow_mode,
    input logic [NUM_PAIRS*8-1:0]         xoff_chars,
    input logic                           stat_rd,
    input logic                           fifo_wr,
    input logic [7:0]                     fifo_wdata,
    input logic                           spec_stat,
    input logic                           xoff_irq,
    input logic                           tx_halt,
    input logic                           tx_resume
);
    logic spec_hit_now;
    assign spec_hit_now = chr_valid && spec_en &&
                          (chr_data == xoff_chars[SPEC_PAIR*8 +: 8]);

    a_r2_write_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> $past(chr_valid));

    a_r2_data_echo: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> (fifo_wdata == $past(chr_data)));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !chr_valid |=> (!fifo_wr && !xoff_irq && !tx_resume));

    a_r3_mode0_stores: assert property (@(posedge clk) disable iff (rst)
        (chr_valid && flow_mode == '0) |=> (fifo_wr && !xoff_irq && !tx_resume));

    a_r4_spec_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(spec_stat) |-> $past(spec_hit_now));

    a_r5_spec_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !spec_hit_now) |=> !spec_stat);

    a_r6_irq_halts: assert property (@(posedge clk) disable iff (rst)
        xoff_irq |-> tx_halt);

    a_r6_resume_releases: assert property (@(posedge clk) disable iff (rst)
        tx_resume |-> !tx_halt);

    a_r10_xoff_wins: assert property (@(posedge clk) disable iff (rst)
        !(xoff_irq && tx_resume));

    a_r11_halt_holds: assert property (@(posedge clk) disable iff (rst)
        !chr_valid |=> $stable(tx_halt));
endmodule

bind rx_flowchar_detect rx_flowchar_detect_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .SPEC_PAIR (SPEC_PAIR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chr_valid  (chr_valid),
    .chr_data   (chr_data),
    .spec_en    (spec_en),
    .flow_mode  (flow_mode),
    .xoff_chars (xoff_chars),
    .stat_rd    (stat_rd),
    .fifo_wr    (fifo_wr),
    .fifo_wdata (fifo_wdata),
    .spec_stat  (spec_stat),
    .xoff_irq   (xoff_irq),
    .tx_halt    (tx_halt),
    .tx_resume  (tx_resume)
);

// File: tb/rx_flowchar_detect_bench.sv
module rx_flowchar_detect_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chr_valid = 1'b0;
    logic [7:0]  chr_data = 8'h00;
    logic        spec_en = 1'b0;
    logic [1:0]  flow_mode = 2'b00;
    logic [15:0] xon_chars = {8'h91, 8'h11};
    logic [15:0] xoff_chars = {8'h93, 8'h13};
    logic        stat_rd = 1'b0;
    logic        fifo_wr;
    logic [7:0]  fifo_wdata;
    logic        spec_stat;
    logic        xoff_irq;
    logic        tx_halt;
    logic        tx_resume;

    int checks = 0;
    int errors = 0;
    logic m_halt = 1'b0;
    logic m_spec = 1'b0;

    always #4 clk = ~clk;

    rx_flowchar_detect u_rx_flowchar_detect (
        .clk (clk), .rst (rst), .chr_valid (chr_valid), .chr_data (chr_data),
        .spec_en (spec_en), .flow_mode (flow_mode), .xon_chars (xon_chars),
        .xoff_chars (xoff_chars), .stat_rd (stat_rd), .fifo_wr (fifo_wr),
        .fifo_wdata (fifo_wdata), .spec_stat (spec_stat), .xoff_irq (xoff_irq),
        .tx_halt (tx_halt), .tx_resume (tx_resume)
    );

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {wr,data,spec,irq,halt,res} actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] outs();
        return {fifo_wr, fifo_wr ? fifo_wdata : 8'h00, spec_stat, xoff_irq, tx_halt, tx_resume};
    endfunction

    // Called at a falling edge: apply inputs, predict, compare at the next falling edge.
    task automatic step(input logic v, input logic [7:0] d, input logic en,
                        input logic [1:0] md, input logic rd, input string tag);
        logic is_on, is_off, e_wr, e_irq, e_res;
        chr_valid = v; chr_data = d; spec_en = en; flow_mode = md; stat_rd = rd;
        is_on  = (md[1] && d == xon_chars[7:0])  || (md[0] && d == xon_chars[15:8]);
        is_off = (md[1] && d == xoff_chars[7:0]) || (md[0] && d == xoff_chars[15:8]);
        e_wr  = v && !is_on && !is_off;
        e_irq = v && is_off;
        e_res = v && is_on && !is_off;
        if (e_irq) m_halt = 1'b1;
        else if (e_res) m_halt = 1'b0;
        m_spec = (v && en && d == xoff_chars[15:8]) || (m_spec && !rd);
        @(negedge clk);
        check(tag, outs(), {e_wr, e_wr ? d : 8'h00, m_spec, e_irq, m_halt, e_res});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] pool [4];
        void'($urandom(32'd7151));
        repeat (3) @(negedge clk);
        check("R1 in reset", outs(), 13'h0);
        // Valid strobe during reset must leave nothing behind.
        chr_valid = 1'b1; chr_data = 8'h13; flow_mode = 2'b11; spec_en = 1'b1;
        @(negedge clk);
        check("R1 reset strobe", outs(), 13'h0);
        rst = 1'b0;
        step(1'b0, 8'h00, 1'b0, 2'b00, 1'b0, "R1 after reset");

        // Mode 00: everything stored.
        step(1'b1, 8'h13, 1'b0, 2'b00, 1'b0, "R3 xoff1 stored");
        step(1'b1, 8'h91, 1'b0, 2'b00, 1'b0, "R3 xon2 stored");
        step(1'b0, 8'h13, 1'b0, 2'b00, 1'b0, "R2 no strobe");
        // Special detection and bit order.
        step(1'b1, 8'h93, 1'b0, 2'b00, 1'b0, "R4 disabled no flag");
        step(1'b1, 8'hC9, 1'b1, 2'b00, 1'b0, "R4 reversed no match");
        step(1'b1, 8'h93, 1'b1, 2'b00, 1'b0, "R4 flag set");
        step(1'b0, 8'h00, 1'b1, 2'b00, 1'b0, "R5 sticky");
        step(1'b1, 8'h93, 1'b1, 2'b00, 1'b1, "R5 set beats clear");
        step(1'b0, 8'h00, 1'b1, 2'b00, 1'b1, "R5 clear");
        // Mode 10: pair 1 live.
        step(1'b1, 8'h13, 1'b1, 2'b10, 1'b0, "R6 xoff1 halts");
        step(1'b1, 8'h42, 1'b1, 2'b10, 1'b0, "R11 halt holds");
        step(1'b1, 8'h93, 1'b1, 2'b10, 1'b0, "R7 xoff2 stored and flagged");
        step(1'b1, 8'h11, 1'b1, 2'b10, 1'b1, "R6 xon1 resumes");
        step(1'b1, 8'h11, 1'b1, 2'b10, 1'b0, "R11 resume when running");
        // Mode 01: pair 2 live.
        step(1'b1, 8'h93, 1'b1, 2'b01, 1'b1, "R8 xoff2 swallowed");
        step(1'b1, 8'h13, 1'b1, 2'b01, 1'b1, "R8 pair1 stored");
        step(1'b1, 8'h91, 1'b0, 2'b01, 1'b0, "R8 xon2 resumes");
        step(1'b1, 8'h93, 1'b0, 2'b01, 1'b0, "R8 xoff2 no flag when disabled");
        // Mode 11: both pairs.
        step(1'b1, 8'h11, 1'b0, 2'b11, 1'b0, "R9 xon1 in both");
        step(1'b1, 8'h13, 1'b0, 2'b11, 1'b0, "R9 xoff1 in both");
        step(1'b1, 8'h91, 1'b0, 2'b11, 1'b0, "R9 xon2 in both");
        // Same value programmed as Xon and Xoff.
        xon_chars[7:0] = 8'h13;
        step(1'b1, 8'h13, 1'b0, 2'b10, 1'b0, "R10 xoff wins");
        xon_chars[7:0] = 8'h11;

        pool[0] = 8'h11; pool[1] = 8'h13; pool[2] = 8'h91; pool[3] = 8'h93;
        for (int i = 0; i < 600; i++) begin
            logic [7:0] d;
            logic [1:0] md;
            d  = ($urandom % 3 == 0) ? 8'($urandom) : pool[$urandom % 4];
            md = 2'($urandom);
            step(($urandom % 4) != 0, d, 1'($urandom), md, ($urandom % 4) == 0,
                 md == 2'b11 ? "R9 random" : "R2 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule